// File: doc/BRIEF.md
# NAND Strobe Timing Controller

This block turns a packed timing word into the NAND bus control strobes for single byte transfers. Software writes a key to a lock register, then one protected register: either the timing word or the interface-control register. The timing word sets, in host clock cycles, how long read-enable and write-enable stay low and high. It also sets the turnaround gap after a transfer, the delay before the ready line is first looked at, and the delay from chip enable to the first strobe. A protected write without the key is dropped and raises an error flag.

A one-cycle request starts a read, a write or a ready wait. The state machine has the states IDLE, CE_SETUP, STB_LOW, STB_HIGH, TURN, BUSY_WAIT and RDY_POLL, and moves through them as follows:

- IDLE → CE_SETUP on a read or write request when chip enable is in normal mode.
- IDLE → STB_LOW on a read or write request when chip enable is forced on.
- IDLE → BUSY_WAIT on a wait request.
- CE_SETUP → STB_LOW, STB_LOW → STB_HIGH, STB_HIGH → TURN, TURN → IDLE and BUSY_WAIT → RDY_POLL, each when that phase's count runs out.
- RDY_POLL → IDLE when the ready input is high.

A read request wins over a write request, and a write request wins over a wait request. Requests that arrive outside IDLE are dropped.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After reset, every timing field holds all ones, both interface-control bits are 0, chip enable is in normal mode, the lock is closed and the error flag is clear. All strobes and chip enable are high, busy is low and the data bus is not driven. With the reset timing, a write transfer gives 4 setup cycles, 16 low cycles and 24 high cycles.
- R2: The protected registers are the timing word (select 1) and interface control (select 2). A write to either takes effect only if the lock (select 0) received the value 0xA25E after the last protected write. Writing any other value to the lock closes it.
- R3: Any protected write closes the lock again, so a second protected write without a new key is dropped.
- R4: A protected write made while the lock is closed leaves the register unchanged and sets prot_err. The next accepted protected write clears prot_err.
- R5: The timing word holds these fields:

  | Bits | Field |
  |------|-------|
  | 3:0 | write low |
  | 7:4 | write high |
  | 11:8 | read low |
  | 15:12 | read high |
  | 18:16 | turnaround |
  | 23:19 | busy delay |
  | 25:24 | CE setup |

  A field value N gives N+1 cycles. A write holds the write-enable output low for write-low + 1 cycles.
- R6: After the low phase, the strobe stays high for (high field + 1) + (turnaround + 1) cycles. done pulses in the last of those cycles, and busy is low in the cycle after it.
- R7: A read holds the read-enable output low for read-low + 1 cycles. rd_data takes the value of nand_dq_in from the last low cycle and shows it from the done cycle onward.
- R8: Bit 0 of the chip-enable mode register (select 3, not protected) set to 1 selects normal mode. In normal mode chip enable is high in IDLE, and it is low for CE-setup + 1 cycles before the strobe falls. With bit 0 cleared, chip enable stays low at all times and the strobe falls in the first cycle after the request.
- R9: After a wait request, nand_rdy is ignored for busy-delay + 1 cycles. done comes in the first later cycle in which nand_rdy is high.
- R10: Interface-control bit 2 drives pg_large and bit 1 drives addr_four.
- R11: A read, write or wait request that arrives while busy is high is ignored. No extra transfer follows, and rd_data keeps its value.
- R12: During a write, nand_dq_oe is high and nand_dq_out carries the requested byte throughout the low phase. During a read, nand_dq_oe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 lock, 1 timing, 2 interface control, 3 chip-enable mode |
| cfg_wdata | input | 32 | Register write data |
| prot_err | output | 1 | Sticky flag for a protected write made without the key |
| pg_large | output | 1 | Large-page mode (interface control bit 2) |
| addr_four | output | 1 | Four address bytes (interface control bit 1) |
| rd_req | input | 1 | One-cycle byte read request |
| wr_req | input | 1 | One-cycle byte write request |
| wait_req | input | 1 | One-cycle request to wait for device ready |
| wr_byte | input | 8 | Byte to write |
| rd_data | output | 8 | Last byte read |
| busy | output | 1 | High whenever the state machine is outside IDLE |
| done | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rdy | input | 1 | Device ready input |

## Verification
Two behaviours are hard to show from the ports.

The first is capture on the final low cycle rather than an earlier one. To expose it, the bench changes nand_dq_in on every low cycle of a read to the number of that cycle. rd_data must then equal the read-low count plus one.

The second is the ready hold-off. The bench drives nand_rdy high before the wait request is accepted, so an early look at the ready input would end the wait too soon. The bench then sweeps all 32 busy-delay values and checks the exact cycle of done, both with ready held high and with ready raised late.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

    typedef enum logic [1:0] {
        SEL_LOCK   = 2'd0,
        SEL_TIMING = 2'd1,
        SEL_IFCTRL = 2'd2,
        SEL_CEMODE = 2'd3
    } cfg_sel_e;

    // Field order follows bit order, MSB first
    typedef struct packed {
        logic [1:0] ce_setup;
        logic [4:0] busy_dly;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } timing_t;

    localparam int TIMING_W = $bits(timing_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CE_SETUP,
        ST_STB_LOW,
        ST_STB_HIGH,
        ST_TURN,
        ST_BUSY_WAIT,
        ST_RDY_POLL
    } phase_e;

endpackage

// File: rtl/nand_cfg_bank.sv
module nand_cfg_bank
    import nand_strobe_pkg::*;
#(
    parameter int          CFG_W = 32,
    parameter logic [31:0] KEY   = 32'h0000_A25E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output timing_t          timing,
    output logic             pg_large,
    output logic             addr_four,
    output logic             ce_normal,
    output logic             lock_open,
    output logic             prot_err
);

    localparam logic [CFG_W-1:0] KEY_W = CFG_W'(KEY);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing    <= '1;
            pg_large  <= 1'b0;
            addr_four <= 1'b0;
            ce_normal <= 1'b1;
            lock_open <= 1'b0;
            prot_err  <= 1'b0;
        end else if (cfg_wr) begin
            unique case (sel)
                SEL_LOCK: lock_open <= (cfg_wdata == KEY_W);
                SEL_TIMING: begin
                    if (lock_open) begin
                        timing    <= cfg_wdata[TIMING_W-1:0];
                        lock_open <= 1'b0;
                        prot_err  <= 1'b0;
                    end else begin
                        prot_err  <= 1'b1;
                    end
                end
                SEL_IFCTRL: begin
                    if (lock_open) begin
                        pg_large  <= cfg_wdata[2];
                        addr_four <= cfg_wdata[1];
                        lock_open <= 1'b0;
                        prot_err  <= 1'b0;
                    end else begin
                        prot_err  <= 1'b1;
                    end
                end
                SEL_CEMODE: ce_normal <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nand_strobe_fsm.sv
module nand_strobe_fsm
    import nand_strobe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  timing_t           tm,
    input  logic              ce_normal,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              wait_req,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              nand_rdy,
    output logic              re_n,
    output logic              we_n,
    output logic              ce_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done
);

    phase_e             state, nxt;
    logic [CNT_W-1:0]   cnt, load;
    logic               op_rd, op_nxt;
    logic [DATA_W-1:0]  byte_q;
    logic               cnt_zero;

    assign cnt_zero = (cnt == '0);

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_req || wr_req)
                    nxt = ce_normal ? ST_CE_SETUP : ST_STB_LOW;
                else if (wait_req)
                    nxt = ST_BUSY_WAIT;
            end
            ST_CE_SETUP:  if (cnt_zero) nxt = ST_STB_LOW;
            ST_STB_LOW:   if (cnt_zero) nxt = ST_STB_HIGH;
            ST_STB_HIGH:  if (cnt_zero) nxt = ST_TURN;
            ST_TURN:      if (cnt_zero) nxt = ST_IDLE;
            ST_BUSY_WAIT: if (cnt_zero) nxt = ST_RDY_POLL;
            ST_RDY_POLL:  if (nand_rdy) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Count loaded on entry to a phase
    always_comb begin
        op_nxt = (state == ST_IDLE) ? rd_req : op_rd;
        load   = '0;
        unique case (nxt)
            ST_CE_SETUP:  load = CNT_W'(tm.ce_setup);
            ST_STB_LOW:   load = op_nxt ? CNT_W'(tm.rd_lo) : CNT_W'(tm.wr_lo);
            ST_STB_HIGH:  load = op_nxt ? CNT_W'(tm.rd_hi) : CNT_W'(tm.wr_hi);
            ST_TURN:      load = CNT_W'(tm.turn);
            ST_BUSY_WAIT: load = CNT_W'(tm.busy_dly);
            default:      load = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (nxt != state) cnt <= load;
        else if (!cnt_zero)    cnt <= cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_rd   <= 1'b0;
            byte_q  <= '0;
            rd_data <= '0;
        end else begin
            if (state == ST_IDLE && (rd_req || wr_req)) begin
                op_rd  <= rd_req;
                byte_q <= wr_byte;
            end
            if (state == ST_STB_LOW && cnt_zero && op_rd)
                rd_data <= dq_in;
        end
    end

    // Outputs
    always_comb begin
        re_n   = !(state == ST_STB_LOW && op_rd);
        we_n   = !(state == ST_STB_LOW && !op_rd);
        ce_n   = ce_normal &&
                 (state == ST_IDLE || state == ST_BUSY_WAIT || state == ST_RDY_POLL);
        dq_oe  = !op_rd &&
                 (state == ST_CE_SETUP || state == ST_STB_LOW || state == ST_STB_HIGH);
        dq_out = byte_q;
        busy   = (state != ST_IDLE);
        done   = (state == ST_TURN && cnt_zero) || (state == ST_RDY_POLL && nand_rdy);
    end

endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
    import nand_strobe_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          CFG_W  = 32,
    parameter int          CNT_W  = 5,
    parameter logic [31:0] KEY    = 32'h0000_A25E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              prot_err,
    output logic              pg_large,
    output logic              addr_four,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              wait_req,
    input  logic [DATA_W-1:0] wr_byte,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              nand_ce_n,
    output logic              nand_re_n,
    output logic              nand_we_n,
    output logic [DATA_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_in,
    input  logic              nand_rdy
);

    timing_t timing_w;
    logic    ce_normal;
    logic    lock_open;

    nand_cfg_bank #(.CFG_W(CFG_W), .KEY(KEY)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .timing    (timing_w),
        .pg_large  (pg_large),
        .addr_four (addr_four),
        .ce_normal (ce_normal),
        .lock_open (lock_open),
        .prot_err  (prot_err)
    );

    nand_strobe_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tm        (timing_w),
        .ce_normal (ce_normal),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .wait_req  (wait_req),
        .wr_byte   (wr_byte),
        .dq_in     (nand_dq_in),
        .nand_rdy  (nand_rdy),
        .re_n      (nand_re_n),
        .we_n      (nand_we_n),
        .ce_n      (nand_ce_n),
        .dq_out    (nand_dq_out),
        .dq_oe     (nand_dq_oe),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk
    import nand_strobe_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_wr,
    input logic [1:0]          cfg_sel,
    input logic                lock_open,
    input logic                prot_err,
    input logic [TIMING_W-1:0] timing,
    input logic                rd_req,
    input logic                wr_req,
    input logic                wait_req,
    input logic                busy,
    input logic                done,
    input logic                re_n,
    input logic                we_n,
    input logic                ce_n
);

    logic prot_sel;
    assign prot_sel = (cfg_sel == 2'd1) || (cfg_sel == 2'd2);

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_open |=> $stable(timing));                                   // R2
    AST_LOCK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && lock_open && prot_sel) |=> !lock_open);                 // R3
    AST_UNKEYED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !lock_open && prot_sel) |=> prot_err);                  // R4
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!re_n && !we_n));                                                // R12
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);                                                   // R6
    AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!re_n || !we_n) |-> !ce_n);                                       // R8
    AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !busy && !rd_req && !wr_req) |=> !done);              // R9

endmodule

bind nand_strobe_ctrl nand_strobe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .lock_open (lock_open),
    .prot_err  (prot_err),
    .timing    (timing_w),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .wait_req  (wait_req),
    .busy      (busy),
    .done      (done),
    .re_n      (nand_re_n),
    .we_n      (nand_we_n),
    .ce_n      (nand_ce_n)
);

// File: tb/nand_strobe_ctrl_tb.sv
module nand_strobe_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        prot_err, pg_large, addr_four;
    logic        rd_req = 1'b0, wr_req = 1'b0, wait_req = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic [7:0]  rd_data;
    logic        busy, done;
    logic        nand_ce_n, nand_re_n, nand_we_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rdy = 1'b0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int last_rd = 0;

    localparam logic [31:0] KEY = 32'h0000_A25E;

    nand_strobe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .prot_err(prot_err), .pg_large(pg_large),
        .addr_four(addr_four), .rd_req(rd_req), .wr_req(wr_req),
        .wait_req(wait_req), .wr_byte(wr_byte), .rd_data(rd_data),
        .busy(busy), .done(done), .nand_ce_n(nand_ce_n),
        .nand_re_n(nand_re_n), .nand_we_n(nand_we_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nfail = nfail + 1;
            nchk  = nchk + 1;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int wl, input int wh, input int rl,
                                       input int rh, input int ta, input int bd,
                                       input int cs);
        logic [31:0] v;
        v = '0;
        v[3:0]   = wl[3:0];
        v[7:4]   = wh[3:0];
        v[11:8]  = rl[3:0];
        v[15:12] = rh[3:0];
        v[18:16] = ta[2:0];
        v[23:19] = bd[4:0];
        v[25:24] = cs[1:0];
        return v;
    endfunction

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_tm(input logic [31:0] d);
        cfg(2'd0, KEY);
        cfg(2'd1, d);
    endtask

    task automatic xfer(input bit rd, input logic [7:0] b,
                        output int pre, output int low, output int post,
                        output int dq_bad);
        bit seen;
        bit fin;
        pre = 0; low = 0; post = 0; dq_bad = 0; seen = 0; fin = 0;
        @(negedge clk);
        rd_req = rd; wr_req = !rd; wr_byte = b; nand_dq_in = '0;
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        for (int g = 0; g < 300; g++) begin
            if ((rd ? nand_re_n : nand_we_n) == 1'b0) begin
                low = low + 1; seen = 1;
                if (rd) begin
                    if (nand_dq_oe) dq_bad = dq_bad + 1;
                    nand_dq_in = low[7:0];
                end else if (!nand_dq_oe || nand_dq_out != b) begin
                    dq_bad = dq_bad + 1;
                end
            end else if (!seen) begin
                if (!nand_ce_n) pre = pre + 1;
            end else begin
                post = post + 1;
            end
            if (done) begin fin = 1; break; end
            @(negedge clk);
        end
        if (!fin) chk("R6 transfer completes", 0, 1);
    endtask

    task automatic wait_rdy(input int rdy_at, output int n);
        bit fin;
        fin = 0;
        nand_rdy = (rdy_at == 0);
        @(negedge clk);
        wait_req = 1'b1;
        @(negedge clk);
        wait_req = 1'b0;
        n = 1;
        for (int g = 0; g < 300; g++) begin
            if (rdy_at != 0 && n == rdy_at) begin nand_rdy = 1'b1; #1; end
            if (done) begin fin = 1; break; end
            n = n + 1;
            @(negedge clk);
        end
        if (!fin) chk("R9 wait completes", 0, 1);
        @(negedge clk);
        nand_rdy = 1'b0;
    endtask

    initial begin
        int pre, low, post, bad, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 ce_n", nand_ce_n, 1);
        chk("R1 re_n", nand_re_n, 1);
        chk("R1 we_n", nand_we_n, 1);
        chk("R1 dq_oe", nand_dq_oe, 0);
        chk("R1 prot_err", prot_err, 0);
        chk("R1 pg_large", pg_large, 0);
        chk("R1 addr_four", addr_four, 0);
        xfer(0, 8'h5A, pre, low, post, bad);
        chk("R1 reset setup", pre, 4);
        chk("R1 reset low", low, 16);
        chk("R1 reset high", post, 24);

        // R4/R2 unkeyed writes dropped
        cfg(2'd1, mk(0, 0, 0, 0, 0, 0, 0));
        chk("R4 err set", prot_err, 1);
        xfer(0, 8'h11, pre, low, post, bad);
        chk("R2 unkeyed timing ignored", low, 16);
        cfg(2'd2, 32'h6);
        chk("R4 unkeyed ifctrl ignored", pg_large, 0);

        // R10/R3 interface control
        cfg(2'd0, KEY); cfg(2'd2, 32'h4);
        chk("R10 pg_large", pg_large, 1);
        chk("R10 addr_four", addr_four, 0);
        chk("R4 err cleared", prot_err, 0);
        cfg(2'd2, 32'h2);
        chk("R3 relock pg_large", pg_large, 1);
        chk("R3 relock addr_four", addr_four, 0);
        chk("R3 relock err", prot_err, 1);
        cfg(2'd0, KEY); cfg(2'd2, 32'h2);
        chk("R10 pg_large off", pg_large, 0);
        chk("R10 addr_four on", addr_four, 1);

        // R2 wrong key closes lock
        cfg(2'd0, KEY); cfg(2'd0, 32'h0000_A25F); cfg(2'd2, 32'h4);
        chk("R2 wrong key", pg_large, 0);
        chk("R2 wrong key err", prot_err, 1);

        // R5/R7/R12 low phase sweep
        for (int v = 0; v < 16; v++) begin
            set_tm(mk(v, 0, 15 - v, 0, 0, 0, 0));
            xfer(0, 8'(8'hA0 + v), pre, low, post, bad);
            chk("R5 write low", low, v + 1);
            chk("R12 write data drive", bad, 0);
            xfer(1, 8'h00, pre, low, post, bad);
            chk("R7 read low", low, 16 - v);
            chk("R12 read bus released", bad, 0);
            chk("R7 capture last low", int'(rd_data), 16 - v);
            last_rd = 16 - v;
        end

        // R6 high phase sweep
        for (int v = 0; v < 16; v++) begin
            set_tm(mk(1, v, 1, 15 - v, 0, 0, 0));
            xfer(0, 8'h3C, pre, low, post, bad);
            chk("R6 write high", post, v + 2);
            @(negedge clk);
            chk("R6 busy after done", busy, 0);
            xfer(1, 8'h00, pre, low, post, bad);
            chk("R6 read high", post, 17 - v);
            last_rd = 2;
        end

        // R6 turnaround sweep
        for (int v = 0; v < 8; v++) begin
            set_tm(mk(0, 3, 0, 0, v, 0, 0));
            xfer(0, 8'h77, pre, low, post, bad);
            chk("R6 turnaround", post, v + 5);
        end

        // R8 CE setup sweep
        for (int v = 0; v < 4; v++) begin
            set_tm(mk(0, 0, 0, 0, 0, 0, v));
            xfer(0, 8'h01, pre, low, post, bad);
            chk("R8 ce setup", pre, v + 1);
            @(negedge clk);
            chk("R8 ce high idle", nand_ce_n, 1);
        end

        // R8 forced chip enable
        cfg(2'd3, 32'h0);
        @(negedge clk);
        chk("R8 forced ce idle", nand_ce_n, 0);
        xfer(0, 8'h02, pre, low, post, bad);
        chk("R8 forced no setup", pre, 0);
        chk("R8 forced low", low, 1);
        cfg(2'd3, 32'h1);
        @(negedge clk);
        chk("R8 normal ce restored", nand_ce_n, 1);

        // R9 busy delay sweep
        for (int v = 0; v < 32; v++) begin
            set_tm(mk(0, 0, 0, 0, 0, v, 0));
            wait_rdy(0, n);
            chk("R9 ready held high", n, v + 2);
            wait_rdy(v + 10, n);
            chk("R9 ready late", n, v + 10);
        end

        // R11 requests while busy dropped
        set_tm(mk(8, 8, 8, 8, 7, 0, 3));
        @(negedge clk);
        wr_req = 1'b1; wr_byte = 8'h99;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b1; nand_dq_in = 8'hEE;
        @(negedge clk);
        rd_req = 1'b0; wait_req = 1'b1;
        @(negedge clk);
        wait_req = 1'b0;
        for (int g = 0; g < 100; g++) begin
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk("R11 no extra transfer", busy, 0);
        @(negedge clk);
        chk("R11 still idle", busy, 0);
        chk("R11 rd_data kept", int'(rd_data), last_rd);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule